// File: doc/BRIEF.md
# Dual-register bidirectional bus transceiver

This block couples two parallel buses, called side A and side B. Each of them is brought out as an input pin, an output pin and an output-enable, so the block can sit on-chip without tri-state cells. The block holds one storage register per side. The A register takes the resolved A-bus value and the B register takes the resolved B-bus value. Each register has its own load strobe, which models that register's private clock edge inside a single clock domain.

Each driving direction has its own output enable, and the two enables have opposite polarity. Each direction also has a select. With the select low, the port carries the live input of the opposite bus. With the select high, it carries the register that holds the opposite side's data. A parameter chooses between true and inverted output data. A register always captures the resolved value of its own bus. When the block itself drives a bus, the register therefore captures that drive. Setting up a live transfer and strobing the far side's register in the same cycle thus leaves the same data in both registers.

Top module: `dual_reg_xcvr`

## Requirements
- R1: With `oe_ab_i` low and `oe_ba_ni` high, neither `a_oe_o` nor `b_oe_o` is asserted, and both registers keep their contents when no load is given.
- R2: `b_oe_o` follows `oe_ab_i` (active high) and `a_oe_o` follows the inverse of `oe_ba_ni` (active low). A port that is not enabled outputs all zeros.
- R3: At a rising clock edge with `ld_a_i` high, the A register takes the resolved A bus, and `ld_b_i` does the same for the B register. The enables have no effect on loading. The resolved A bus is `a_o` when `a_oe_o` is high and `a_i` otherwise, and the same rule applies to the B bus.
- R4: A register whose load strobe is low keeps its value across the clock edge.
- R5: `sel_ab_i` = 0 places `a_i` on `b_o`. `sel_ab_i` = 1 places the A register on `b_o`. The value passes through the polarity of R9.
- R6: `sel_ba_i` = 0 places `b_i` on `a_o`. `sel_ba_i` = 1 places the B register on `a_o`. The value passes through the polarity of R9.
- R7: Take `oe_ab_i` = 1, `sel_ab_i` = 0, A not driven and `ld_b_i` = 1. The B register then captures the polarity-applied `a_i`, so the same A data is held on both sides when `ld_a_i` is also given. The mirror case, with `oe_ba_ni` = 0, `sel_ba_i` = 0, B not driven and `ld_a_i` = 1, stores `b_i` data.
- R8: With both ports enabled and both selects at 1, `b_o` carries the A register and `a_o` carries the B register in the same cycle.
- R9: With `INVERT` = 0, the output data is true. With `INVERT` = 1, every driven bit is the complement of its source.
- R10: After `rst_ni` is asserted low, both registers read zero.
- R11: Loads that occur at the same edge use values from before the edge. During a stored exchange with both strobes high, each register takes the polarity-applied old value of the other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ab_i | input | 1 | Enables driving of the B port, active high |
| oe_ba_ni | input | 1 | Enables driving of the A port, active low |
| sel_ab_i | input | 1 | Source for B output: 0 live A, 1 A register |
| sel_ba_i | input | 1 | Source for A output: 0 live B, 1 B register |
| ld_a_i | input | 1 | Load strobe of the A register |
| ld_b_i | input | 1 | Load strobe of the B register |
| a_i | input | WIDTH | External value on A bus |
| a_o | output | WIDTH | Data driven onto A bus |
| a_oe_o | output | 1 | A bus drive enable |
| b_i | input | WIDTH | External value on B bus |
| b_o | output | WIDTH | Data driven onto B bus |
| b_oe_o | output | 1 | B bus drive enable |

## Verification
The assertions assume that the control and data inputs are settled before each rising edge and hold known values while reset is released. The bench changes every input only on the falling edge. Because the live path always takes the opposite external pin, the stimulus may enable both live directions at once without forming a loop. Loads issued in the same cycle during a stored exchange are specified as sampling values from before the edge, so the random mix may include them freely. The directed sequence still applies staggered strobes for the loopback cases.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  // R3
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
  // R4
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             en_i,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  input  logic [WIDTH-1:0] ext_i,
  output logic [WIDTH-1:0] drive_o,
  output logic             oe_o,
  output logic [WIDTH-1:0] bus_o
);
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] pol;
  src_sel_e         sel;

  assign sel = src_sel_e'(sel_i);
  assign src = (sel == SRC_STORED) ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign pol = ~src;
    end else begin : g_true
      assign pol = src;
    end
  endgenerate

  assign oe_o    = en_i;
  assign drive_o = en_i ? pol : '0;
  // resolved bus seen by this side's register
  assign bus_o   = en_i ? pol : ext_i;

  // R2
  always_comb begin
    if (!$isunknown(en_i) && !$isunknown(drive_o))
      a_r2_quiet: assert (en_i || drive_o == '0);
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oe_ab_i,
  input  logic             oe_ba_ni,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             ld_a_i,
  input  logic             ld_b_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  localparam logic [WIDTH-1:0] PolMask = INVERT ? '1 : '0;

  logic [WIDTH-1:0] q_a, q_b;
  logic [WIDTH-1:0] bus_a, bus_b;

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_a_i), .d_i(bus_a), .q_o(q_a)
  );

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_b_i), .d_i(bus_b), .q_o(q_b)
  );

  // live source is always the opposite external pin: no combinational loop
  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_b (
    .en_i(oe_ab_i), .sel_i(sel_ab_i), .live_i(a_i), .stored_i(q_a),
    .ext_i(b_i), .drive_o(b_o), .oe_o(b_oe_o), .bus_o(bus_b)
  );

  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_a (
    .en_i(~oe_ba_ni), .sel_i(sel_ba_i), .live_i(b_i), .stored_i(q_b),
    .ext_i(a_i), .drive_o(a_o), .oe_o(a_oe_o), .bus_o(bus_a)
  );

  // R1
  a_r1_isolation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ab_i && oe_ba_ni) |-> (!a_oe_o && !b_oe_o));
  // R7
  a_r7_loop_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_b_i && oe_ab_i && !sel_ab_i) |=> (q_b == ($past(a_i) ^ PolMask)));
  // R7 mirror
  a_r7_loop_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_a_i && !oe_ba_ni && !sel_ba_i) |=> (q_a == ($past(b_i) ^ PolMask)));
  // R8
  a_r8_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ab_i && !oe_ba_ni && sel_ab_i && sel_ba_i) |->
      (b_o == (q_a ^ PolMask) && a_o == (q_b ^ PolMask)));
  // R11
  a_r11_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_a_i && ld_b_i && oe_ab_i && !oe_ba_ni && sel_ab_i && sel_ba_i) |=>
      (q_a == ($past(q_b) ^ PolMask) && q_b == ($past(q_a) ^ PolMask)));
endmodule

// File: tb/dual_reg_xcvr_tb.sv
module dual_reg_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic oe_ab, oe_ba_n, sel_ab, sel_ba, ld_a, ld_b;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] t_a, t_b, i_a, i_b;
  logic t_aoe, t_boe, i_aoe, i_boe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] mt_ra, mt_rb, mi_ra, mi_rb;

  always #2.5 clk = ~clk;

  dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ab_i(oe_ab), .oe_ba_ni(oe_ba_n),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .ld_a_i(ld_a), .ld_b_i(ld_b),
    .a_i(a_in), .a_o(t_a), .a_oe_o(t_aoe), .b_i(b_in), .b_o(t_b), .b_oe_o(t_boe)
  );

  dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ab_i(oe_ab), .oe_ba_ni(oe_ba_n),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .ld_a_i(ld_a), .ld_b_i(ld_b),
    .a_i(a_in), .a_o(i_a), .a_oe_o(i_aoe), .b_i(b_in), .b_o(i_b), .b_oe_o(i_boe)
  );

  function automatic logic [W-1:0] pol(input logic [W-1:0] x, input bit inv);
    return inv ? ~x : x;
  endfunction

  function automatic logic [W-1:0] exp_b(input logic [W-1:0] ra, input bit inv);
    return oe_ab ? pol(sel_ab ? ra : a_in, inv) : '0;
  endfunction

  function automatic logic [W-1:0] exp_a(input logic [W-1:0] rb, input bit inv);
    return !oe_ba_n ? pol(sel_ba ? rb : b_in, inv) : '0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit eab, input bit ebn, input bit sab,
                      input bit sba, input bit la, input bit lb,
                      input logic [W-1:0] av, input logic [W-1:0] bv);
    logic [W-1:0] nt_ra, nt_rb, ni_ra, ni_rb;
    oe_ab = eab; oe_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    ld_a = la; ld_b = lb; a_in = av; b_in = bv;
    #1;
    check({tag, " R2 b_oe"}, W'(t_boe), W'(eab));
    check({tag, " R2 a_oe"}, W'(t_aoe), W'(!ebn));
    check({tag, " R5 b_o"}, t_b, exp_b(mt_ra, 1'b0));
    check({tag, " R6 a_o"}, t_a, exp_a(mt_rb, 1'b0));
    check({tag, " R9 inv b_o"}, i_b, exp_b(mi_ra, 1'b1));
    check({tag, " R9 inv a_o"}, i_a, exp_a(mi_rb, 1'b1));
    check({tag, " R9 inv oe"}, W'({i_aoe, i_boe}), W'({!ebn, eab}));
    nt_ra = la ? (!ebn ? exp_a(mt_rb, 1'b0) : av) : mt_ra;
    nt_rb = lb ? (eab ? exp_b(mt_ra, 1'b0) : bv) : mt_rb;
    ni_ra = la ? (!ebn ? exp_a(mi_rb, 1'b1) : av) : mi_ra;
    ni_rb = lb ? (eab ? exp_b(mi_ra, 1'b1) : bv) : mi_rb;
    @(posedge clk);
    mt_ra = nt_ra; mt_rb = nt_rb; mi_ra = ni_ra; mi_rb = ni_rb;
    @(negedge clk);
  endtask

  // stored exchange readout, no loads
  task automatic readout(input string tag);
    step(tag, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    oe_ab = 0; oe_ba_n = 1; sel_ab = 0; sel_ba = 0; ld_a = 0; ld_b = 0;
    a_in = '0; b_in = '0;
    mt_ra = '0; mt_rb = '0; mi_ra = '0; mi_rb = '0;
    repeat (3) @(negedge clk);
    // R10: loads pulsed during reset must not stick
    ld_a = 1; ld_b = 1; a_in = 8'hff; b_in = 8'hff;
    @(negedge clk);
    rst_ni = 1'b1;
    readout("R10 reset");
    check("R10 reg_a zero", t_b, 8'h00);
    check("R10 reg_b zero", t_a, 8'h00);

    // R1 isolation, no loads
    step("R1 iso", 0, 1, 0, 0, 0, 0, 8'h12, 8'h34);
    readout("R1 iso keep");

    // R3 store both while isolated
    step("R3 store", 0, 1, 0, 0, 1, 1, 8'h5a, 8'hc3);
    readout("R3 read");
    check("R3 reg_a", t_b, 8'h5a);
    check("R3 reg_b", t_a, 8'hc3);

    // R4 hold: new bus data without loads
    step("R4 hold", 0, 1, 0, 1, 0, 0, 8'h99, 8'h66);
    readout("R4 read");
    check("R4 reg_a kept", t_b, 8'h5a);

    // R8 exchange
    step("R8 exch", 1, 0, 1, 1, 0, 0, 8'h0f, 8'hf0);
    check("R8 b from reg_a", t_b, 8'h5a);

    // R7 staggered: A live onto B, load B then A
    step("R7 ld_b", 1, 1, 0, 0, 0, 1, 8'h3c, 8'h00);
    step("R7 ld_a", 1, 1, 0, 0, 1, 0, 8'h3c, 8'h00);
    readout("R7 read");
    check("R7 both hold A", t_a, 8'h3c);
    check("R7 both hold A inv", i_a, 8'h3c);
    // mirror: B live onto A, load A
    step("R7 mirror", 0, 0, 0, 0, 1, 0, 8'h00, 8'ha5);
    readout("R7 mirror read");
    check("R7 mirror reg_a", t_b, 8'ha5);

    // R11 simultaneous loads during stored exchange
    step("R11 swap", 1, 0, 1, 1, 1, 1, 8'h00, 8'h00);
    readout("R11 read");

    // R5 / R6 live transfers
    step("R5 live", 1, 1, 0, 0, 0, 0, 8'h81, 8'h18);
    step("R6 live", 0, 0, 0, 0, 0, 0, 8'h81, 8'h18);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] ctl;
      ctl = 8'($urandom);
      step((i % 2) ? "R6 rnd" : "R5 rnd", ctl[0], ctl[1], ctl[2], ctl[3],
           ctl[4], ctl[5], 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule